// File: doc/BRIEF.md
# Transceiver Configuration Port Bridge

This block lets a 32-bit memory-mapped bus reach the 16-bit dynamic configuration ports of several transceiver lanes and one shared PLL. Software first writes a control word that picks one port and opens access. Bus reads and writes inside an address window are then turned into handshaked transactions on the picked port. For each transaction the bridge sends a one-cycle enable pulse with write-enable, register address and write data. It then waits for that port's ready strobe.

Window writes are posted. The bus is acknowledged at once, and a busy flag in the control word stays set until the port answers. Window reads hold the bus response until ready arrives and return the port data zero-extended. A window access that arrives while busy is stalled until the outstanding transaction is done. This keeps a read issued right after a write ordered behind that write. The target can be changed by rewriting the control word, with no need to close access first.

Top module: `cfg_port_bridge`

## Requirements
- R1: Control word (byte offset 0x0) select field: bit 0 to bit 3 pick lane ports 0 to 3 and bit 4 picks the PLL port (port index 4). A window access raises the enable of the picked port only, and the control word reads back the select bits that were written.
- R2: Bit 16 of the control word opens port access and reads back as written. After reset the control word reads 0. Writing 0 to the whole word closes access, and later window accesses reach no port.
- R3: Bit 20 of the control word reads 1 while a port transaction is outstanding and 0 once the port has answered.
- R4: A bus access at byte offset 0x2000 + (A << 2), with A from 0 to 511, reaches configuration register A. The port address driven with the enable equals A.
- R5: A window read returns the 16-bit port data in bits 15:0, with bits 31:16 zero. A read after a write to the same register returns the value written.
- R6: Rewriting the control word with a different select while access is open moves later window accesses to the new port.
- R7: With the enable bit 0, or with no select bit set, a window access is acknowledged without any port enable. A read returns 0, and a write is dropped so that the register keeps its old value.
- R8: A window access issued while busy gets no bus acknowledge until the outstanding transaction has finished, and it is then carried out in order.
- R9: A window read is acknowledged only after the picked port raises ready. Busy clears on the same clock edge as that acknowledge.
- R10: When more than one select bit is set, the lowest-numbered set bit picks the port.
- R11: Each port enable is a single-cycle pulse, at most one port enable is high at a time, and no second enable is issued before the port answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request, held until bus_ack |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | ADDR_W (14) | Byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| port_en | output | N_LANE+N_PLL (5) | Per-port enable pulse |
| port_we | output | 1 | Port write-enable, valid with port_en |
| port_addr | output | CFG_AW (9) | Configuration register address |
| port_wdata | output | DATA_W (16) | Port write data |
| port_rdata | input | (N_LANE+N_PLL)*DATA_W (80) | Read data of all ports, port i in slice i |
| port_rdy | input | N_LANE+N_PLL (5) | Per-port ready strobe |

## Verification
A wrong latched target or a wrong select priority shows up as soon as the next port enable: the enable pulse lands on the wrong port, and the readback of a swept value comes back with another port's pattern. A busy flag that clears too early or too late shows up within the next few cycles. Either the control word reports the wrong state while the slow modelled port is still counting, or a read issued right after a posted write returns stale data. The window mapping and the enable gating are swept over every port and over addresses across the full register range. Any error in the address offset or in dropping writes therefore appears at the first access that touches the register involved.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

   // Decoded class of a bus address
   typedef enum logic [1:0] {
      CPB_NONE = 2'd0,
      CPB_CTRL = 2'd1,
      CPB_WIN  = 2'd2
   } cpb_kind_t;

endpackage

// File: rtl/cpb_decode.sv
module cpb_decode
   import cpb_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int CFG_AW    = 9,
   parameter int WIN_BASE  = 'h800,
   parameter int CTRL_WORD = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output cpb_kind_t         kind,
   output logic [CFG_AW-1:0] cfg_addr
);
   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] BASE_W = WORD_W'(WIN_BASE);
   localparam logic [WORD_W-1:0] CTRL_W = WORD_W'(CTRL_WORD);

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] off;
   logic              in_win;

   always_comb begin
      word     = addr[ADDR_W-1:2];
      off      = word - BASE_W;
      in_win   = (word >= BASE_W) && ((off >> CFG_AW) == '0);
      cfg_addr = off[CFG_AW-1:0];
      if (word == CTRL_W)
         kind = CPB_CTRL;
      else if (in_win)
         kind = CPB_WIN;
      else
         kind = CPB_NONE;
   end
endmodule

// File: rtl/cpb_target.sv
module cpb_target #(
   parameter int NPORT = 5
) (
   input  logic [NPORT-1:0] sel,
   output logic [NPORT-1:0] pick_oh,
   output logic             hit
);
   // lower_any[i] is set when any select bit below i is set
   logic [NPORT:0] lower_any;

   assign lower_any[0] = 1'b0;

   for (genvar i = 0; i < NPORT; i++) begin : g_prio
      assign lower_any[i+1] = lower_any[i] | sel[i];
      assign pick_oh[i]     = sel[i] & ~lower_any[i];
   end

   assign hit = lower_any[NPORT];
endmodule

// File: rtl/cpb_rd_mux.sv
module cpb_rd_mux #(
   parameter int NPORT  = 5,
   parameter int DATA_W = 16
) (
   input  logic [NPORT*DATA_W-1:0] data,
   input  logic [NPORT-1:0]        oh,
   output logic [DATA_W-1:0]       q
);
   logic [DATA_W-1:0] part [NPORT];

   for (genvar i = 0; i < NPORT; i++) begin : g_mask
      assign part[i] = data[i*DATA_W +: DATA_W] & {DATA_W{oh[i]}};
   end

   always_comb begin
      q = '0;
      for (int i = 0; i < NPORT; i++) q = q | part[i];
   end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cpb_pkg::*;
#(
   parameter int N_LANE   = 4,
   parameter int N_PLL    = 1,
   parameter int ADDR_W   = 14,
   parameter int CFG_AW   = 9,
   parameter int DATA_W   = 16,
   parameter int WIN_BASE = 'h800,
   parameter int EN_BIT   = 16,
   parameter int BUSY_BIT = 20,
   localparam int NPORT   = N_LANE + N_PLL
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic                    bus_ack,
   output logic [31:0]             bus_rdata,
   output logic [NPORT-1:0]        port_en,
   output logic                    port_we,
   output logic [CFG_AW-1:0]       port_addr,
   output logic [DATA_W-1:0]       port_wdata,
   input  logic [NPORT*DATA_W-1:0] port_rdata,
   input  logic [NPORT-1:0]        port_rdy
);
   // Elaboration-time parameter checks
   if (NPORT < 1 || NPORT > EN_BIT) begin : g_bad_nport
      $error("port count must be between 1 and EN_BIT");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_dw
      $error("DATA_W must be between 1 and 32");
   end
   if (EN_BIT >= BUSY_BIT || BUSY_BIT > 31) begin : g_bad_bits
      $error("control bit positions out of order");
   end
   if (WIN_BASE + (1 << CFG_AW) > (1 << (ADDR_W - 2))) begin : g_bad_win
      $error("window does not fit in the address space");
   end

   cpb_kind_t         kind;
   logic [CFG_AW-1:0] cfg_a;
   logic [NPORT-1:0]  sel_q;
   logic              en_q;
   logic [NPORT-1:0]  pick_oh;
   logic              pick_hit;
   logic              busy_q;
   logic              rd_pend_q;
   logic [NPORT-1:0]  tgt_oh_q;
   logic [DATA_W-1:0] rd_sel;
   logic              rdy_hit;
   logic              accept;
   logic              live;
   logic [31:0]       ctrl_word;

   cpb_decode #(
      .ADDR_W   (ADDR_W),
      .CFG_AW   (CFG_AW),
      .WIN_BASE (WIN_BASE),
      .CTRL_WORD(0)
   ) u_dec (
      .addr    (bus_addr),
      .kind    (kind),
      .cfg_addr(cfg_a)
   );

   cpb_target #(.NPORT(NPORT)) u_tgt (
      .sel    (sel_q),
      .pick_oh(pick_oh),
      .hit    (pick_hit)
   );

   cpb_rd_mux #(.NPORT(NPORT), .DATA_W(DATA_W)) u_mux (
      .data(port_rdata),
      .oh  (tgt_oh_q),
      .q   (rd_sel)
   );

   assign rdy_hit = busy_q && ((port_rdy & tgt_oh_q) != '0);
   assign accept  = bus_req && !bus_ack;
   assign live    = en_q && pick_hit;

   always_comb begin
      ctrl_word               = '0;
      ctrl_word[NPORT-1:0]    = sel_q;
      ctrl_word[EN_BIT]       = en_q;
      ctrl_word[BUSY_BIT]     = busy_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q      <= '0;
         en_q       <= 1'b0;
         busy_q     <= 1'b0;
         rd_pend_q  <= 1'b0;
         tgt_oh_q   <= '0;
         bus_ack    <= 1'b0;
         bus_rdata  <= '0;
         port_en    <= '0;
         port_we    <= 1'b0;
         port_addr  <= '0;
         port_wdata <= '0;
      end else begin
         bus_ack <= 1'b0;
         port_en <= '0;

         // Completion of the outstanding port transaction
         if (rdy_hit) begin
            busy_q <= 1'b0;
            if (rd_pend_q) begin
               rd_pend_q <= 1'b0;
               bus_ack   <= 1'b1;
               bus_rdata <= 32'(rd_sel);
            end
         end

         // New bus request
         if (accept) begin
            unique case (kind)
               CPB_CTRL: begin
                  bus_ack   <= 1'b1;
                  bus_rdata <= ctrl_word;
                  if (bus_we) begin
                     sel_q <= bus_wdata[NPORT-1:0];
                     en_q  <= bus_wdata[EN_BIT];
                  end
               end
               CPB_WIN: begin
                  if (busy_q) begin
                     // stall: request stays pending on the bus
                  end else if (!live) begin
                     bus_ack   <= 1'b1;
                     bus_rdata <= '0;
                  end else begin
                     port_en    <= pick_oh;
                     port_we    <= bus_we;
                     port_addr  <= cfg_a;
                     port_wdata <= bus_wdata[DATA_W-1:0];
                     tgt_oh_q   <= pick_oh;
                     busy_q     <= 1'b1;
                     if (bus_we) begin
                        bus_ack   <= 1'b1;
                        bus_rdata <= '0;
                     end else begin
                        rd_pend_q <= 1'b1;
                     end
                  end
               end
               default: begin
                  bus_ack   <= 1'b1;
                  bus_rdata <= '0;
               end
            endcase
         end
      end
   end

   // R11
   en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_en));

   // R11
   en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en != '0) |=> (port_en == '0));

   // R2
   en_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en != '0) |-> (en_q && busy_q));

   // R10
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en != '0) |-> (((sel_q & (port_en - 1'b1)) == '0) && ((sel_q & port_en) != '0)));

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !rdy_hit) |=> busy_q);

   // R9
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_hit |=> !busy_q);

   // R9
   rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pend_q && !rdy_hit) |=> !bus_ack);

   // R7
   off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == CPB_WIN && !busy_q && !live) |=> (bus_ack && port_en == '0));

   // R8
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && kind == CPB_WIN && busy_q && !rd_pend_q && !rdy_hit) |=> !bus_ack);

endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;
   localparam int NPORT = 5;
   localparam int DW    = 16;
   localparam int AW    = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0;
   logic              bus_we = 1'b0;
   logic [13:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_ack;
   logic [31:0]       bus_rdata;
   logic [NPORT-1:0]  port_en;
   logic              port_we;
   logic [AW-1:0]     port_addr;
   logic [DW-1:0]     port_wdata;
   logic [NPORT*DW-1:0] port_rdata;
   logic [NPORT-1:0]  port_rdy;

   always #2 clk = ~clk;  // 250 MHz

   cfg_port_bridge dut (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .port_en(port_en), .port_we(port_we), .port_addr(port_addr), .port_wdata(port_wdata),
      .port_rdata(port_rdata), .port_rdy(port_rdy)
   );

   // ---------------- port models ----------------
   logic [DW-1:0] mem [NPORT][1<<AW];
   int            cnt [NPORT];
   logic [DW-1:0] hold [NPORT];
   int            en_count [NPORT];
   logic [AW-1:0] last_addr;
   int            extra_lat = 0;
   int            pulse_err = 0;
   logic [NPORT-1:0] prev_en = '0;

   initial begin
      for (int p = 0; p < NPORT; p++) begin
         cnt[p] = 0; hold[p] = '0; en_count[p] = 0;
         for (int a = 0; a < (1<<AW); a++) mem[p][a] = '0;
      end
      port_rdy = '0;
      port_rdata = '0;
   end

   always @(posedge clk) begin
      prev_en <= port_en;
      if ((prev_en & port_en) != '0) pulse_err++;
      for (int p = 0; p < NPORT; p++) begin
         port_rdy[p] <= 1'b0;
         if (cnt[p] != 0) begin
            cnt[p] <= cnt[p] - 1;
            if (cnt[p] == 1) begin
               port_rdy[p] <= 1'b1;
               port_rdata[p*DW +: DW] <= hold[p];
            end
         end
         if (port_en[p]) begin
            en_count[p]++;
            last_addr <= port_addr;
            cnt[p] <= 1 + ((p + int'(port_addr)) % 4) + extra_lat;
            if (port_we) begin
               mem[p][port_addr] <= port_wdata;
               hold[p] <= port_wdata;
            end else begin
               hold[p] <= mem[p][port_addr];
            end
         end
      end
   end

   // ---------------- bench infrastructure ----------------
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit we, input int addr, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = 14'(addr); bus_wdata = wd;
      cyc = 0;
      forever begin
         @(posedge clk); #1;
         cyc++;
         if (bus_ack) break;
         if (cyc > 2000) begin
            failures++;
            $display("FAIL R9 no bus_ack actual=0x0 expected=0x1");
            break;
         end
      end
      rd = bus_rdata;
      bus_req = 1'b0;
   endtask

   function automatic logic [15:0] pat(input int p, input int a);
      return 16'((p * 'h1357) ^ (a * 'h0101) ^ 'hA5C3);
   endfunction

   function automatic int waddr(input int a);
      return 'h2000 + (a << 2);
   endfunction

   int snap [NPORT];
   task automatic snap_counts();
      for (int p = 0; p < NPORT; p++) snap[p] = en_count[p];
   endtask

   // count of ports whose enable count moved since the snapshot, and which one
   function automatic int moved(output int which);
      int n = 0;
      which = -1;
      for (int p = 0; p < NPORT; p++)
         if (en_count[p] != snap[p]) begin n++; which = p; end
      return n;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] rd;
      int cyc;
      int w;
      int n;

      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      // R2 reset state
      check(bus_ack == 1'b0 && port_en == '0, "R2 reset outputs", {bus_ack, port_en}, 0);
      xfer(0, 0, 0, rd, cyc);
      check(rd == 32'h0, "R2 reset control word", rd, 0);

      // R1 R4 R5 R8 sweep over every port and spread addresses
      for (int p = 0; p < NPORT; p++) begin
         xfer(1, 0, (32'h1 << p) | (32'h1 << 16), rd, cyc);
         xfer(0, 0, 0, rd, cyc);
         check(rd == ((32'h1 << p) | (32'h1 << 16)), "R1 control readback", rd,
               (32'h1 << p) | (32'h1 << 16));
         for (int k = 0; k < 12; k++) begin
            int a = (k == 11) ? 511 : k * 47;
            snap_counts();
            xfer(1, waddr(a), {16'hDEAD, pat(p, a)}, rd, cyc);
            repeat (1) @(posedge clk); #1;
            n = moved(w);
            check(n == 1 && w == p, "R1 enable on picked port only", w, p);
            check(last_addr == AW'(a), "R4 port address", last_addr, a);
            // R8: read issued right behind the posted write
            xfer(0, waddr(a), 0, rd, cyc);
            check(rd == {16'h0, pat(p, a)}, "R5 R8 readback after write", rd, {16'h0, pat(p, a)});
         end
      end

      // R3 busy flag with a slow port
      extra_lat = 10;
      xfer(1, 0, 32'h1 | (32'h1 << 16), rd, cyc);
      xfer(1, waddr(7), 32'h0000_1234, rd, cyc);
      xfer(0, 0, 0, rd, cyc);
      check(rd[20] == 1'b1, "R3 busy while outstanding", rd[20], 1);
      repeat (30) @(posedge clk);
      xfer(0, 0, 0, rd, cyc);
      check(rd[20] == 1'b0, "R3 busy cleared", rd[20], 0);

      // R9 read held until ready, busy clear with ack
      xfer(0, waddr(7), 0, rd, cyc);
      check(rd == 32'h1234, "R9 slow read data", rd, 32'h1234);
      check(cyc >= 12, "R9 read waits for ready", cyc, 12);
      xfer(0, 0, 0, rd, cyc);
      check(rd[20] == 1'b0, "R9 busy cleared with ack", rd[20], 0);
      extra_lat = 0;

      // R7 enable bit off
      xfer(1, 0, 32'h1, rd, cyc);
      snap_counts();
      xfer(1, waddr(7), 32'h0000_BEEF, rd, cyc);
      check(cyc <= 2, "R7 disabled write acked at once", cyc, 1);
      xfer(0, waddr(7), 0, rd, cyc);
      check(rd == 32'h0, "R7 disabled read returns 0", rd, 0);
      n = moved(w);
      check(n == 0, "R7 no port enable while disabled", n, 0);
      // R7 enabled but no select bit
      xfer(1, 0, 32'h1 << 16, rd, cyc);
      snap_counts();
      xfer(1, waddr(7), 32'h0000_BEEF, rd, cyc);
      xfer(0, waddr(7), 0, rd, cyc);
      n = moved(w);
      check(n == 0 && rd == 32'h0, "R7 no select no access", {n, rd}, 0);
      xfer(1, 0, 32'h1 | (32'h1 << 16), rd, cyc);
      xfer(0, waddr(7), 0, rd, cyc);
      check(rd == 32'h1234, "R7 dropped write left value", rd, 32'h1234);

      // R10 lowest set select bit wins
      xfer(1, 0, 32'h16 | (32'h1 << 16), rd, cyc);
      snap_counts();
      xfer(1, waddr(300), 32'h0000_7777, rd, cyc);
      repeat (1) @(posedge clk); #1;
      n = moved(w);
      check(n == 1 && w == 1, "R10 lowest bit wins", w, 1);
      xfer(0, waddr(300), 0, rd, cyc);
      check(rd == 32'h7777, "R10 data from port 1", rd, 32'h7777);

      // R6 retarget without disabling
      xfer(1, 0, 32'h4 | (32'h1 << 16), rd, cyc);
      xfer(1, waddr(100), 32'h0000_2222, rd, cyc);
      xfer(1, 0, 32'h8 | (32'h1 << 16), rd, cyc);
      snap_counts();
      xfer(1, waddr(100), 32'h0000_3333, rd, cyc);
      repeat (1) @(posedge clk); #1;
      n = moved(w);
      check(n == 1 && w == 3, "R6 retarget port", w, 3);
      xfer(0, waddr(100), 0, rd, cyc);
      check(rd == 32'h3333, "R6 new target data", rd, 32'h3333);
      xfer(1, 0, 32'h4 | (32'h1 << 16), rd, cyc);
      xfer(0, waddr(100), 0, rd, cyc);
      check(rd == 32'h2222, "R6 old target untouched", rd, 32'h2222);

      // R2 teardown with a zero write
      xfer(1, 0, 32'h0, rd, cyc);
      xfer(0, 0, 0, rd, cyc);
      check(rd == 32'h0, "R2 teardown readback", rd, 0);
      snap_counts();
      xfer(1, waddr(100), 32'h0000_4444, rd, cyc);
      xfer(0, waddr(100), 0, rd, cyc);
      n = moved(w);
      check(n == 0 && rd == 32'h0, "R2 no access after teardown", {n, rd}, 0);

      // R11 enable pulses were single-cycle throughout
      check(pulse_err == 0, "R11 single-cycle enable", pulse_err, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule